// File: doc/BRIEF.md
# Quad-Line Serial PSRAM Bring-Up Sequencer

This block takes a serial pseudo-static RAM from an unknown line mode to quad mode after power-up. It needs no processor. A single `start` pulse launches a fixed chain of serial commands on chip select, a serial clock and four data lines. The chain first forces the device out of quad mode and then reads its 24-bit identifier in single-line mode. It qualifies that identifier, reading it a second time if the first answer is not trusted. It then soft-resets the device and switches it to quad mode.

While the identifier is being checked, the block also decodes it into a manufacturer class and a capacity in bytes. The size, the error flag, the manufacturer class and the quad-active flag are held in registers. They stay valid until the next `start`, and a one-cycle `done` pulse marks the end of every sequence, whether it passed or failed.

Each serial bit takes two system clocks. The serial clock is low in the first cycle, when the block changes its data. It is high in the second cycle, when the device samples the data and the block samples returned data. Only data line 1 carries returned data.

Top module: `qpsram_bringup`

## Requirements
- R1: While reset is applied and afterwards until `start`, `cs_n` is 1, `sck` is 0, `dq_oe` is 0, and `done`, `err`, `quad_on`, `mfr_alt` and `size_bytes` are 0.
- R2: The first frame carries opcode 0xF5 as two nibbles on all four lines (`dq_oe` = 4'hF, high nibble first, line 3 holding the nibble's MSB), two serial clocks in total.
- R3: The identifier read sends opcode 0x9F and then 24 zero address bits MSB first on line 0 only (`dq_oe` = 4'h1). It follows them at once with 24 receive clocks (56 serial clocks in all, no dummy). In those clocks no line is driven and line 1 is sampled. The first byte received becomes identifier bits [7:0], the second bits [15:8] and the third bits [23:16], each byte arriving MSB first.
- R4: An identifier is accepted only when bits [15:8] equal 0x5D. If the first read fails this check, exactly one more read is issued, and the decode uses the identifier from that second read.
- R5: If both reads fail, the sequence stops after the second read. It then pulses `done` with `err` = 1, `quad_on` = 0, `mfr_alt` = 0 and `size_bytes` = 0, and sends no further frame.
- R6: With manufacturer byte (bits [7:0]) 0x9D, `mfr_alt` = 1 and capacity codes 0, 1 and 2 give 1, 2 and 4 MiB. Any other manufacturer gives `mfr_alt` = 0 and 2, 4 and 8 MiB. The capacity code is identifier bits [23:21].
- R7: A capacity code of 3 to 7 gives `size_bytes` = 0 without raising `err`.
- R8: When identifier bits [23:16] equal 0x26, `size_bytes` is 8 MiB (0x800000) for either manufacturer class.
- R9: After an accepted identifier, three single-line 8-bit frames follow, each in its own chip-select window: 0x66, then 0x99, then 0x35. `quad_on` rises in the same cycle as the final `done`.
- R10: Between frames `cs_n` stays high for at least two clocks. Whenever `cs_n` is high, `sck` is low and `dq_oe` is 0. Output data never changes while `sck` is high.
- R11: `done` is a one-cycle pulse, given once per sequence. A `start` clears `err`, `quad_on`, `mfr_alt` and `size_bytes`. A `start` arriving while a sequence runs has no effect, so the frame list and the results are those of the single sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches the bring-up sequence |
| dq1_in | input | 1 | Returned serial data from data line 1 |
| sck | output | 1 | Serial clock to the device |
| cs_n | output | 1 | Active-low chip select |
| dq_o | output | 4 | Data driven onto the four lines |
| dq_oe | output | 4 | Per-line output enable |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Both identifier reads failed |
| quad_on | output | 1 | Device has been switched to quad mode |
| mfr_alt | output | 1 | Alternate-manufacturer capacity table in use |
| size_bytes | output | 24 | Decoded capacity in bytes, 0 if unknown |

## Verification
The sequence is exercised with a set of identifiers chosen to tell the decode paths apart:
- Generic and alternate manufacturers with capacity codes 0 and 2 separate the two tables.
- The 0x26 extended byte paired with each manufacturer shows the override beating a table lookup that would give 4 or 2 MiB.
- Codes 3 and 7 show a zero size with no error.

The retry path is probed in two ways:
- A bad first identifier followed by a good one with different content shows that the decode uses the second read.
- Two bad reads, one of them off by a single bit in the good-die byte, show the stop after the second read with no reset or quad frames.

Finally, a run with a second `start` mid-sequence, and a run right after a failure, show that the frame list comes from one sequence only and that `start` clears the results.

// File: rtl/qpb_pkg.sv
package qpb_pkg;

    localparam int SIZE_W   = 24;
    localparam int ID_W     = 24;
    localparam int OP_W     = 8;
    localparam int SHIFT_W  = OP_W + ID_W;
    localparam int ID_BEATS = OP_W + ID_W + ID_W;
    localparam int BEAT_W   = $clog2(ID_BEATS);

    localparam logic [OP_W-1:0] OP_QUAD_EXIT = 8'hF5;
    localparam logic [OP_W-1:0] OP_READ_ID   = 8'h9F;
    localparam logic [OP_W-1:0] OP_RST_EN    = 8'h66;
    localparam logic [OP_W-1:0] OP_RST_GO    = 8'h99;
    localparam logic [OP_W-1:0] OP_QUAD_EN   = 8'h35;
    localparam logic [7:0]      GOOD_DIE     = 8'h5D;
    localparam logic [7:0]      MFR_ALT_CODE = 8'h9D;
    localparam logic [7:0]      EXT_FORCE_8M = 8'h26;

    localparam logic [SIZE_W-1:0] MIB = SIZE_W'(24'h100000);

    typedef enum logic [2:0] {
        STP_QEXIT,
        STP_ID_A,
        STP_ID_B,
        STP_RST_EN,
        STP_RST_GO,
        STP_QEN
    } step_e;

    typedef struct packed {
        logic [OP_W-1:0] op;
        logic            quad;
        logic            idread;
    } frame_t;

    typedef struct packed {
        logic              valid;
        logic              alt;
        logic [SIZE_W-1:0] bytes;
    } ident_t;

    function automatic frame_t frame_for(step_e s);
        frame_t f;
        case (s)
            STP_QEXIT:          f = '{op: OP_QUAD_EXIT, quad: 1'b1, idread: 1'b0};
            STP_ID_A, STP_ID_B: f = '{op: OP_READ_ID,   quad: 1'b0, idread: 1'b1};
            STP_RST_EN:         f = '{op: OP_RST_EN,    quad: 1'b0, idread: 1'b0};
            STP_RST_GO:         f = '{op: OP_RST_GO,    quad: 1'b0, idread: 1'b0};
            default:            f = '{op: OP_QUAD_EN,   quad: 1'b0, idread: 1'b0};
        endcase
        return f;
    endfunction

    function automatic ident_t decode_id(logic [ID_W-1:0] id);
        ident_t     r;
        logic [2:0] code;
        code    = id[23:21];
        r.valid = (id[15:8] == GOOD_DIE);
        r.alt   = (id[7:0] == MFR_ALT_CODE);
        r.bytes = '0;
        if (id[23:16] == EXT_FORCE_8M)
            r.bytes = MIB << 3;
        else if (code < 3'd3)
            r.bytes = (r.alt ? MIB : (MIB << 1)) << code;
        return r;
    endfunction

endpackage

// File: rtl/qpb_frame_shift.sv
module qpb_frame_shift
    import qpb_pkg::*;
#(
    parameter int GAP_CYC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  frame_t          fr,
    input  logic            miso,
    output logic            fin,
    output logic            sck,
    output logic            cs_n,
    output logic [3:0]      dq_o,
    output logic [3:0]      dq_oe,
    output logic [ID_W-1:0] rx_id
);
    localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_GAP} sh_e;

    sh_e                sh;
    logic [SHIFT_W-1:0] shreg;
    logic [BEAT_W-1:0]  beat, last_beat, tx_end;
    logic               ph, quad_r;
    logic [GAP_W-1:0]   gapc;
    logic [ID_W-1:0]    rxsr;
    logic               tx_phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= SH_IDLE;
            shreg     <= '0;
            beat      <= '0;
            last_beat <= '0;
            tx_end    <= '0;
            ph        <= 1'b0;
            quad_r    <= 1'b0;
            gapc      <= '0;
            rxsr      <= '0;
            cs_n      <= 1'b1;
            fin       <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (sh)
                SH_IDLE: if (go) begin
                    sh        <= SH_RUN;
                    cs_n      <= 1'b0;
                    ph        <= 1'b0;
                    beat      <= '0;
                    shreg     <= {fr.op, {ID_W{1'b0}}};
                    quad_r    <= fr.quad;
                    last_beat <= fr.quad ? BEAT_W'(1) :
                                 (fr.idread ? BEAT_W'(ID_BEATS - 1) : BEAT_W'(OP_W - 1));
                    tx_end    <= fr.quad ? BEAT_W'(2) :
                                 (fr.idread ? BEAT_W'(OP_W + ID_W) : BEAT_W'(OP_W));
                end
                SH_RUN: begin
                    if (!ph) begin
                        ph <= 1'b1;
                    end else begin
                        ph <= 1'b0;
                        if (beat >= tx_end)
                            rxsr <= {rxsr[ID_W-2:0], miso};
                        shreg <= quad_r ? (shreg << 4) : (shreg << 1);
                        if (beat == last_beat) begin
                            sh   <= SH_GAP;
                            cs_n <= 1'b1;
                            gapc <= '0;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                default: begin
                    gapc <= gapc + 1'b1;
                    if (gapc == GAP_W'(GAP_CYC - 1)) begin
                        fin <= 1'b1;
                        sh  <= SH_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        tx_phase = (sh == SH_RUN) && (beat < tx_end);
        sck      = ph;
        if (!tx_phase) begin
            dq_o  = 4'h0;
            dq_oe = 4'h0;
        end else if (quad_r) begin
            dq_o  = shreg[SHIFT_W-1 -: 4];
            dq_oe = 4'hF;
        end else begin
            dq_o  = {3'b000, shreg[SHIFT_W-1]};
            dq_oe = 4'h1;
        end
        rx_id = {rxsr[7:0], rxsr[15:8], rxsr[23:16]};
    end

endmodule

// File: rtl/qpb_ctrl.sv
module qpb_ctrl
    import qpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fin,
    input  logic [ID_W-1:0]   rx_id,
    output logic              go,
    output frame_t            fr,
    output logic              done,
    output logic              err,
    output logic              quad_on,
    output logic              mfr_alt,
    output logic [SIZE_W-1:0] size_bytes
);
    typedef enum logic [1:0] {C_IDLE, C_LAUNCH, C_WAIT} ctl_e;

    ctl_e   cs;
    step_e  step;
    ident_t info;

    assign info = decode_id(rx_id);
    assign go   = (cs == C_LAUNCH);
    assign fr   = frame_for(step);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs         <= C_IDLE;
            step       <= STP_QEXIT;
            done       <= 1'b0;
            err        <= 1'b0;
            quad_on    <= 1'b0;
            mfr_alt    <= 1'b0;
            size_bytes <= '0;
        end else begin
            done <= 1'b0;
            case (cs)
                C_IDLE: if (start) begin
                    cs         <= C_LAUNCH;
                    step       <= STP_QEXIT;
                    err        <= 1'b0;
                    quad_on    <= 1'b0;
                    mfr_alt    <= 1'b0;
                    size_bytes <= '0;
                end
                C_LAUNCH: cs <= C_WAIT;
                default: if (fin) begin
                    cs <= C_LAUNCH;
                    case (step)
                        STP_QEXIT: step <= STP_ID_A;
                        STP_ID_A, STP_ID_B: begin
                            if (info.valid) begin
                                size_bytes <= info.bytes;
                                mfr_alt    <= info.alt;
                                step       <= STP_RST_EN;
                            end else if (step == STP_ID_A) begin
                                step <= STP_ID_B;
                            end else begin
                                err  <= 1'b1;
                                done <= 1'b1;
                                cs   <= C_IDLE;
                            end
                        end
                        STP_RST_EN: step <= STP_RST_GO;
                        STP_RST_GO: step <= STP_QEN;
                        default: begin
                            quad_on <= 1'b1;
                            done    <= 1'b1;
                            cs      <= C_IDLE;
                        end
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/qpsram_bringup.sv
module qpsram_bringup
    import qpb_pkg::*;
#(
    parameter int GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dq1_in,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        dq_o,
    output logic [3:0]        dq_oe,
    output logic              done,
    output logic              err,
    output logic              quad_on,
    output logic              mfr_alt,
    output logic [SIZE_W-1:0] size_bytes
);
    logic            go, fin;
    frame_t          fr;
    logic [ID_W-1:0] rx_id;

    qpb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .fin        (fin),
        .rx_id      (rx_id),
        .go         (go),
        .fr         (fr),
        .done       (done),
        .err        (err),
        .quad_on    (quad_on),
        .mfr_alt    (mfr_alt),
        .size_bytes (size_bytes)
    );

    qpb_frame_shift #(.GAP_CYC(GAP_CYC)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .fr    (fr),
        .miso  (dq1_in),
        .fin   (fin),
        .sck   (sck),
        .cs_n  (cs_n),
        .dq_o  (dq_o),
        .dq_oe (dq_oe),
        .rx_id (rx_id)
    );

endmodule

// File: rtl/qpsram_bringup_chk.sv
module qpsram_bringup_chk (
    input logic       clk,
    input logic       rst,
    input logic       sck,
    input logic       cs_n,
    input logic [3:0] dq_o,
    input logic [3:0] dq_oe,
    input logic       done,
    input logic       err,
    input logic       quad_on
);
    a_r10_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);

    a_r10_sck_idle: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    a_r10_lines_released: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (dq_oe == 4'h0));

    a_r10_data_hold: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sck) |-> $stable(dq_o));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_err_no_quad: assert property (@(posedge clk) disable iff (rst)
        err |-> !quad_on);

    a_r9_quad_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(quad_on) |-> done);

endmodule

bind qpsram_bringup qpsram_bringup_chk u_chk (.*);

// File: tb/qpsram_bringup_test.sv
`timescale 1ns/1ps
module qpsram_bringup_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dq1_in = 1'b0;
    logic        sck, cs_n, done, err, quad_on, mfr_alt;
    logic [3:0]  dq_o, dq_oe;
    logic [23:0] size_bytes;

    always #2 clk = ~clk;

    qpsram_bringup uut (
        .clk(clk), .rst(rst), .start(start), .dq1_in(dq1_in),
        .sck(sck), .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe),
        .done(done), .err(err), .quad_on(quad_on), .mfr_alt(mfr_alt),
        .size_bytes(size_bytes)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mon_bad = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // device model: frame capture and identifier response
    logic [23:0] id_tab [2];
    int          rd_idx = 0;
    int          rc = 0;
    int          ntx = 0;
    logic [31:0] txv = '0;
    bit          sawquad = 0;
    int q_op[$], q_quad[$], q_ntx[$], q_rc[$], q_addr[$];

    always @(negedge cs_n) begin
        rc = 0; ntx = 0; txv = '0; sawquad = 0;
    end

    always @(posedge sck) if (!cs_n) begin
        rc++;
        if (dq_oe == 4'hF) begin
            txv = {txv[27:0], dq_o}; ntx += 4; sawquad = 1;
        end else if (dq_oe == 4'h1) begin
            txv = {txv[30:0], dq_o[0]}; ntx++;
        end
    end

    always @(negedge sck) begin
        if (!cs_n && ntx == 32 && txv[31:24] == 8'h9F && rc >= 32 && rc < 56) begin
            logic [23:0] cur, strm;
            cur  = id_tab[(rd_idx > 1) ? 1 : rd_idx];
            strm = {cur[7:0], cur[15:8], cur[23:16]};
            dq1_in = strm[55 - rc];
        end
    end

    always @(posedge cs_n) if (rc > 0) begin
        int op;
        op = (ntx >= 32) ? int'(txv[31:24]) : int'(txv[7:0]);
        q_op.push_back(op);
        q_quad.push_back(int'(sawquad));
        q_ntx.push_back(ntx);
        q_rc.push_back(rc);
        q_addr.push_back(int'(txv[23:0]));
        if (op == 'h9F) rd_idx++;
        rc = 0;
    end

    // per-clock protocol monitor (R10)
    always @(negedge clk) if (!rst && cs_n && (sck || dq_oe != 4'h0)) mon_bad++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_case(input string nm, input logic [23:0] ida, input logic [23:0] idb,
                            input bit restart_mid);
        bit  v1, v2, fail;
        logic [23:0] used;
        longint esize;
        int  ealt, code, nd;
        int  eop[$];
        v1   = (ida[15:8] == 8'h5D);
        v2   = (idb[15:8] == 8'h5D);
        fail = !v1 && !v2;
        used = v1 ? ida : idb;
        esize = 0;
        ealt  = 0;
        if (!fail) begin
            ealt = (used[7:0] == 8'h9D) ? 1 : 0;
            code = int'(used[23:21]);
            if (used[23:16] == 8'h26) esize = 8 * 1048576;
            else if (code < 3) esize = (ealt ? 1048576 : 2097152) * (longint'(1) << code);
        end
        eop.push_back('hF5);
        eop.push_back('h9F);
        if (!v1) eop.push_back('h9F);
        if (!fail) begin
            eop.push_back('h66); eop.push_back('h99); eop.push_back('h35);
        end

        q_op.delete(); q_quad.delete(); q_ntx.delete(); q_rc.delete(); q_addr.delete();
        id_tab[0] = ida; id_tab[1] = idb; rd_idx = 0;

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R11", {nm, " start clears err"}, err, 0);
        chk("R11", {nm, " start clears size"}, size_bytes, 0);
        chk("R11", {nm, " start clears quad_on"}, quad_on, 0);
        if (restart_mid) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        nd = 0;
        for (int i = 0; i < 4000 && nd == 0; i++) begin
            @(negedge clk);
            if (done) nd++;
        end
        repeat (12) begin
            @(negedge clk);
            if (done) nd++;
        end
        chk("R11", {nm, " done pulses"}, nd, 1);

        chk("R4", {nm, " frame count"}, q_op.size(), eop.size());
        for (int i = 0; i < eop.size() && i < q_op.size(); i++) begin
            chk("R9", {nm, " frame opcode"}, q_op[i], eop[i]);
            chk("R2", {nm, " frame quad lanes"}, q_quad[i], (i == 0) ? 1 : 0);
            chk("R3", {nm, " frame tx bits"}, q_ntx[i], (eop[i] == 'h9F) ? 32 : 8);
            chk("R3", {nm, " frame clocks"}, q_rc[i],
                (i == 0) ? 2 : ((eop[i] == 'h9F) ? 56 : 8));
            if (eop[i] == 'h9F) chk("R3", {nm, " zero address"}, q_addr[i], 0);
        end
        chk("R5", {nm, " err"}, err, fail);
        chk("R9", {nm, " quad_on"}, quad_on, !fail);
        chk("R6", {nm, " mfr_alt"}, mfr_alt, ealt);
        chk("R7", {nm, " size"}, size_bytes, esize);
        repeat (10) @(negedge clk);
        chk("R11", {nm, " size held"}, size_bytes, esize);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1", "reset cs_n", cs_n, 1);
        chk("R1", "reset sck", sck, 0);
        chk("R1", "reset dq_oe", dq_oe, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset err/quad/alt", {err, quad_on, mfr_alt}, 0);
        chk("R1", "reset size", size_bytes, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", "idle cs_n", cs_n, 1);

        run_case("R6 generic code2",  {8'h40, 8'h5D, 8'h0D}, 24'h0, 0);
        run_case("R6 alt code0",      {8'h00, 8'h5D, 8'h9D}, 24'h0, 0);
        run_case("R6 alt code2",      {8'h40, 8'h5D, 8'h9D}, 24'h0, 0);
        run_case("R6 generic code0",  {8'h1F, 8'h5D, 8'h0D}, 24'h0, 0);
        run_case("R8 force generic",  {8'h26, 8'h5D, 8'h0D}, 24'h0, 0);
        run_case("R8 force alt",      {8'h26, 8'h5D, 8'h9D}, 24'h0, 0);
        run_case("R7 code3",          {8'h60, 8'h5D, 8'h0D}, 24'h0, 0);
        run_case("R7 code7",          {8'hE0, 8'h5D, 8'h9D}, 24'h0, 0);
        run_case("R4 retry",          {8'h40, 8'hA5, 8'h0D}, {8'h20, 8'h5D, 8'h9D}, 0);
        run_case("R5 both bad",       {8'h40, 8'h00, 8'h0D}, {8'h40, 8'h5C, 8'h0D}, 0);
        run_case("R11 after error",   {8'h20, 8'h5D, 8'h0D}, 24'h0, 0);
        run_case("R11 start ignored", {8'h20, 8'h5D, 8'h0D}, 24'h0, 1);

        chk("R10", "idle protocol violations", mon_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule